// File: doc/BRIEF.md
# Multiprocessor Serial Transceiver with Address Wakeup

This block is an asynchronous serial transceiver for a shared link where one master talks to several slave controllers. A two-bit mode field picks the framing: 8 data bits, optionally followed by a parity bit, or 9 data bits. In the 9-bit framing the ninth bit tags a frame as an address (1) or as data (0). A slave that sets its wakeup enable receives only address frames. Data frames meant for other slaves never reach its receive buffer and never interrupt it.

Software reaches the block through a small register bus. There is a control register, a status register that reports the received ninth bit and the error flags, and a data register. Writing the data register starts a transmission. Reading it takes the received byte. A baud divisor input sets the 16x oversampling rate that the transmitter and the receiver share. The block drives the TXD line and two interrupt outputs, one for the end of a transmission and one for a received frame.

Top module: `mpu_uart`

## Requirements
- R1: After reset, `txd` is 1, both interrupt outputs are 0, and the control register (address 0) and the status register (address 1) read 0x00. Address 2 is the data register.
- R2: A transmitted frame is one low start bit, then the 8 data bits LSB first, then an optional extra bit, then one high stop bit. Each bit lasts 16 oversampling ticks, one tick every `baud_div`+1 clocks. The idle line is high.
- R3: Control bits [1:0] equal to 11 select 9-bit mode, and every other value selects 8-bit mode. In 9-bit mode, control bit 5 is sent as the ninth bit, and a received ninth bit is stored in status bit 7.
- R4: In 8-bit mode, control bit 2 adds a parity bit after the data. Control bit 3 picks even parity (1) or odd parity (0). A received parity mismatch sets status bit 3.
- R5: In 9-bit mode no parity is generated or checked, even with control bit 2 set. The frame carries the ninth bit instead and never sets status bit 3.
- R6: In 9-bit mode with wakeup enable (control bit 4) set, a frame whose ninth bit is 0 is dropped. The receive buffer, the status register and `rx_irq` stay unchanged.
- R7: A stop bit sampled low sets the framing error flag, status bit 2. The frame's data is still delivered.
- R8: A frame that completes while the previous byte is still unread sets the overrun flag, status bit 4. The buffer then holds the newer byte.
- R9: Reading the status register clears bits 4 to 2. A nonzero value of status AND 0x1C signals an error.
- R10: `tx_irq` is a one-clock pulse after the stop bit has been sent. Status bit 5 shows a transmission in progress, and a data write during that time is ignored.
- R11: Each accepted frame gives a one-clock `rx_irq` pulse and sets status bit 6. Reading the data register clears status bit 6.
- R12: The receiver starts a frame only on a falling edge. The start bit must still be low, by majority of the middle samples, at mid-bit, so a short low glitch produces no frame.
- R13: With control bit 6 (receive enable) at 0, the receiver ignores the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| baud_div | input | DIV_W | Oversampling tick period minus one, in clocks |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_irq | output | 1 | Transmit-complete pulse |
| rx_irq | output | 1 | Frame-received pulse |

## Verification
The assertions check, on every cycle, the properties that relate signals over time:
- both interrupts are single-cycle pulses;
- a transmission opens with a low start bit and has ended when `tx_irq` fires;
- a wakeup-filtered interrupt always comes with a stored ninth bit of 1;
- an arrival into a full buffer raises overrun;
- a status read leaves the error flags clear.

Only the bench scenarios can show the rest. These are the bit-level content of frames through a TXD-to-RXD loopback and the frame durations for 10- and 11-bit formats. They also include parity in both senses, parity being ignored in 9-bit mode, dropped data frames under wakeup, glitch rejection, the receive-enable gate, and the order in which overrun, clear-on-read and buffer release interact.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;
  localparam logic [1:0] MODE_NINE = 2'b11;

  // control register layout, bit 6 down to bit 0
  typedef struct packed {
    logic       rx_en;     // bit 6
    logic       tx_b9;     // bit 5
    logic       wake_en;   // bit 4
    logic       par_even;  // bit 3
    logic       par_en;    // bit 2
    logic [1:0] mode;      // bits 1:0
  } ctrl_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_XTRA,
    RX_STOP
  } rx_state_t;

endpackage

// File: rtl/mpu_baud.sv
module mpu_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_n;

  assign tick = (cnt_q == div);

  always_comb begin
    if (tick) cnt_n = '0;
    else      cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

endmodule

// File: rtl/mpu_tx.sv
module mpu_tx #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] data,
  input  logic          has_x,
  input  logic          xbit,
  output logic          txd,
  output logic          busy,
  output logic          done
);

  localparam int FW   = DW + 3;
  localparam int PH_W = $clog2(OVS);
  localparam int CW   = $clog2(FW + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

  logic [FW-1:0]   sh_q, sh_n;
  logic [CW-1:0]   left_q, left_n;
  logic [PH_W-1:0] ph_q, ph_n;
  logic            busy_q, busy_n;
  logic            done_q, done_n;

  always_comb begin
    sh_n   = sh_q;
    left_n = left_q;
    ph_n   = ph_q;
    busy_n = busy_q;
    done_n = 1'b0;
    if (!busy_q) begin
      if (load) begin
        busy_n = 1'b1;
        ph_n   = '0;
        if (has_x) begin
          sh_n   = {1'b1, xbit, data, 1'b0};
          left_n = CW'(FW);
        end else begin
          sh_n   = {2'b11, data, 1'b0};
          left_n = CW'(FW - 1);
        end
      end
    end else if (tick) begin
      if (ph_q == PH_LAST) begin
        ph_n   = '0;
        sh_n   = {1'b1, sh_q[FW-1:1]};
        left_n = left_q - 1'b1;
        if (left_q == CW'(1)) begin
          busy_n = 1'b0;
          done_n = 1'b1;
        end
      end else begin
        ph_n = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      ph_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      left_q <= left_n;
      ph_q   <= ph_n;
      busy_q <= busy_n;
      done_q <= done_n;
    end
  end

  assign txd  = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/mpu_rx.sv
module mpu_rx import mpu_pkg::*; #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          en,
  input  logic          has_x,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          xbit,
  output logic          stop_bad
);

  localparam int PH_W  = $clog2(OVS);
  localparam int IDX_W = $clog2(DW);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(OVS - 1);
  localparam logic [PH_W-1:0]  MID_LO   = PH_W'(OVS / 2 - 1);
  localparam logic [PH_W-1:0]  MID_HI   = PH_W'(OVS / 2 + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DW - 1);

  logic            s1_q, s2_q;
  logic            prev_q, prev_n;
  rx_state_t       st_q, st_n;
  logic [PH_W-1:0] ph_q, ph_n;
  logic [1:0]      vote_q, vote_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [DW-1:0]   dat_q, dat_n;
  logic            x_q, x_n;
  logic            bad_q, bad_n;
  logic            hx_q, hx_n;
  logic            done_q, done_n;
  logic [2:0]      v3;
  logic            maj;
  logic            in_win;

  assign v3     = {vote_q, s2_q};
  assign maj    = (v3[0] & v3[1]) | (v3[0] & v3[2]) | (v3[1] & v3[2]);
  assign in_win = (ph_q >= MID_LO) && (ph_q <= MID_HI);

  always_comb begin
    prev_n = prev_q;
    st_n   = st_q;
    ph_n   = ph_q;
    vote_n = vote_q;
    idx_n  = idx_q;
    dat_n  = dat_q;
    x_n    = x_q;
    bad_n  = bad_q;
    hx_n   = hx_q;
    done_n = 1'b0;
    if (tick) begin
      prev_n = s2_q;
      if (st_q == RX_IDLE) begin
        if (en && prev_q && !s2_q) begin
          st_n = RX_START;
          ph_n = '0;
          hx_n = has_x;
        end
      end else begin
        ph_n = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
        if (in_win) vote_n = v3[1:0];
        case (st_q)
          RX_START: begin
            if (ph_q == MID_HI && maj) begin
              st_n = RX_IDLE;
            end else if (ph_q == PH_LAST) begin
              st_n  = RX_DATA;
              idx_n = '0;
            end
          end
          RX_DATA: begin
            if (ph_q == MID_HI) dat_n = {maj, dat_q[DW-1:1]};
            if (ph_q == PH_LAST) begin
              if (idx_q == IDX_LAST) st_n = hx_q ? RX_XTRA : RX_STOP;
              else                   idx_n = idx_q + 1'b1;
            end
          end
          RX_XTRA: begin
            if (ph_q == MID_HI)  x_n  = maj;
            if (ph_q == PH_LAST) st_n = RX_STOP;
          end
          RX_STOP: begin
            if (ph_q == MID_HI) begin
              bad_n  = !maj;
              done_n = 1'b1;
              st_n   = RX_IDLE;
            end
          end
          default: st_n = RX_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
      st_q   <= RX_IDLE;
      ph_q   <= '0;
      vote_q <= '0;
      idx_q  <= '0;
      dat_q  <= '0;
      x_q    <= 1'b0;
      bad_q  <= 1'b0;
      hx_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      s1_q   <= rxd;
      s2_q   <= s1_q;
      prev_q <= prev_n;
      st_q   <= st_n;
      ph_q   <= ph_n;
      vote_q <= vote_n;
      idx_q  <= idx_n;
      dat_q  <= dat_n;
      x_q    <= x_n;
      bad_q  <= bad_n;
      hx_q   <= hx_n;
      done_q <= done_n;
    end
  end

  assign done     = done_q;
  assign data     = dat_q;
  assign xbit     = x_q;
  assign stop_bad = bad_q;

endmodule

// File: rtl/mpu_uart.sv
module mpu_uart import mpu_pkg::*; #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             rxd,
  output logic             txd,
  output logic             tx_irq,
  output logic             rx_irq
);

  // reset: asserted asynchronously, released on the clock
  logic rs1_q, rs2_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_core_n = rs2_q;

  ctrl_t      ctrl_q, ctrl_n;
  logic [7:0] rbuf_q, rbuf_n;
  logic       rb9_q, rb9_n;
  logic       full_q, full_n;
  logic       ovr_q, ovr_n;
  logic       perr_q, perr_n;
  logic       ferr_q, ferr_n;
  logic       rxirq_q, rxirq_n;

  logic       tick;
  logic       nine_mode;
  logic       has_x;
  logic       tx_xbit;
  logic       tx_load;
  logic       tx_busy;
  logic       tx_done;
  logic       rx_done;
  logic [7:0] rx_data;
  logic       rx_x;
  logic       rx_bad;
  logic       rx_accept;
  logic       rx_par_bad;
  logic       rd_stat;
  logic       rd_data;

  assign nine_mode = (ctrl_q.mode == MODE_NINE);
  assign has_x     = nine_mode | ctrl_q.par_en;
  assign tx_xbit   = nine_mode ? ctrl_q.tx_b9
                   : (ctrl_q.par_even ? ^wdata : ~^wdata);
  assign tx_load   = wr_en && (addr == REG_DATA);
  assign rd_stat   = rd_en && (addr == REG_STAT);
  assign rd_data   = rd_en && (addr == REG_DATA);

  mpu_baud #(.DIV_W(DIV_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_core_n),
    .div   (baud_div),
    .tick  (tick)
  );

  mpu_tx #(.OVS(OVS), .DW(8)) u_tx (
    .clk   (clk),
    .rst_n (rst_core_n),
    .tick  (tick),
    .load  (tx_load),
    .data  (wdata),
    .has_x (has_x),
    .xbit  (tx_xbit),
    .txd   (txd),
    .busy  (tx_busy),
    .done  (tx_done)
  );

  mpu_rx #(.OVS(OVS), .DW(8)) u_rx (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .tick     (tick),
    .rxd      (rxd),
    .en       (ctrl_q.rx_en),
    .has_x    (has_x),
    .done     (rx_done),
    .data     (rx_data),
    .xbit     (rx_x),
    .stop_bad (rx_bad)
  );

  // wakeup filter: data frames are dropped before touching any state
  assign rx_accept  = rx_done && !(nine_mode && ctrl_q.wake_en && !rx_x);
  assign rx_par_bad = !nine_mode && ctrl_q.par_en &&
                      (rx_x != (ctrl_q.par_even ? ^rx_data : ~^rx_data));

  always_comb begin
    ctrl_n  = ctrl_q;
    rbuf_n  = rbuf_q;
    rb9_n   = rb9_q;
    full_n  = full_q;
    rxirq_n = rx_accept;
    if (wr_en && (addr == REG_CTRL)) ctrl_n = ctrl_t'(wdata[6:0]);
    if (rd_data) full_n = 1'b0;
    if (rx_accept) begin
      rbuf_n = rx_data;
      full_n = 1'b1;
      if (nine_mode) rb9_n = rx_x;
    end
    ovr_n  = (rd_stat ? 1'b0 : ovr_q)  | (rx_accept && full_q);
    perr_n = (rd_stat ? 1'b0 : perr_q) | (rx_accept && rx_par_bad);
    ferr_n = (rd_stat ? 1'b0 : ferr_q) | (rx_accept && rx_bad);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ctrl_q  <= '0;
      rbuf_q  <= '0;
      rb9_q   <= 1'b0;
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      rxirq_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_n;
      rbuf_q  <= rbuf_n;
      rb9_q   <= rb9_n;
      full_q  <= full_n;
      ovr_q   <= ovr_n;
      perr_q  <= perr_n;
      ferr_q  <= ferr_n;
      rxirq_q <= rxirq_n;
    end
  end

  always_comb begin
    case (addr)
      REG_CTRL: rdata = {1'b0, ctrl_q};
      REG_STAT: rdata = {rb9_q, full_q, tx_busy, ovr_q, perr_q, ferr_q, 2'b00};
      REG_DATA: rdata = rbuf_q;
      default:  rdata = 8'h00;
    endcase
  end

  assign tx_irq = tx_done;
  assign rx_irq = rxirq_q;

endmodule

// File: rtl/mpu_uart_chk.sv
module mpu_uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       tx_irq,
  input logic       rx_irq,
  input logic       tx_busy,
  input logic       nine,
  input logic       wake,
  input logic       rb9,
  input logic       accept,
  input logic       full,
  input logic       rd_stat,
  input logic [2:0] errs
);

  // R10
  tx_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);

  // R10
  tx_irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (!tx_busy && txd));

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);

  // R11
  rx_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  // R11
  rx_irq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> full);

  // R6
  wake_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && nine && wake) |-> rb9);

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && full) |=> errs[2]);

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !accept) |=> (errs == 3'b000));

endmodule

bind mpu_uart mpu_uart_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .txd     (txd),
  .tx_irq  (tx_irq),
  .rx_irq  (rx_irq),
  .tx_busy (tx_busy),
  .nine    (nine_mode),
  .wake    (ctrl_q.wake_en),
  .rb9     (rb9_q),
  .accept  (rx_accept),
  .full    (full_q),
  .rd_stat (rd_stat),
  .errs    ({ovr_q, perr_q, ferr_q})
);

// File: tb/sim_mpu_uart.sv
module sim_mpu_uart;

  localparam int DIV = 3;
  localparam int TK  = DIV + 1;
  localparam int BT  = 16 * TK;
  localparam int WD  = 120000;

  typedef struct {
    logic [7:0] d;
    logic       b9;
    logic       chk9;
    logic [2:0] errs;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rxd_b = 1'b1;
  logic       loop_sel = 1'b0;
  logic       rxd_w;
  logic       txd, tx_irq, rx_irq;

  int   n_chk = 0;
  int   n_err = 0;
  int   rxi_cnt = 0;
  int   txi_cnt = 0;
  logic mon_auto = 1'b1;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  assign rxd_w = loop_sel ? txd : rxd_b;

  mpu_uart u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .rdata    (rdata),
    .baud_div (16'(DIV)),
    .rxd      (rxd_w),
    .txd      (txd),
    .tx_irq   (tx_irq),
    .rx_irq   (rx_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] v);
    addr = a; wdata = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: scoreboard side, reads status then data on each receive pulse
  always begin
    @(negedge clk);
    if (tx_irq) txi_cnt++;
    if (rx_irq) begin
      rxi_cnt++;
      if (mon_auto) begin
        if (sb.size() == 0) begin
          chk("R11 unexpected frame", 8'h01, 8'h00);
        end else begin
          exp_t e;
          logic [7:0] s, d, m;
          e = sb[0];
          m = e.chk9 ? 8'hDC : 8'h5C;
          bus_rd(2'd1, s);
          chk("R3/R4/R7 status", s & m, {e.b9, 1'b1, 1'b0, e.errs, 2'b00} & m);
          bus_rd(2'd2, d);
          chk("R2 received data", d, e.d);
          void'(sb.pop_front());
        end
      end
    end
  end

  task automatic push(input logic [7:0] d, input logic b9, input logic c9, input logic [2:0] er);
    exp_t e;
    e.d = d; e.b9 = b9; e.chk9 = c9; e.errs = er;
    sb.push_back(e);
  endtask

  // driver: transmit through loopback and check the frame duration
  task automatic send_tx(input logic [7:0] d, input logic b9, input logic c9, input int nb);
    int cyc, lo, hi;
    @(negedge clk);
    bus_wr(2'd2, d);
    push(d, b9, c9, 3'b000);
    cyc = 0;
    while (!tx_irq) begin
      @(negedge clk);
      cyc++;
    end
    lo = nb * BT - 2 * TK;
    hi = nb * BT + 2 * TK;
    chk("R2 frame length", 8'((cyc >= lo) && (cyc <= hi)), 8'h01);
    @(negedge clk);
    chk("R10 tx_irq one cycle", 8'(tx_irq), 8'h00);
    wait (sb.size() == 0);
  endtask

  task automatic ser_rx(input logic [7:0] d, input logic hx, input logic xb, input logic stop);
    @(negedge clk);
    rxd_b = 1'b0;
    repeat (BT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_b = d[i];
      repeat (BT) @(negedge clk);
    end
    if (hx) begin
      rxd_b = xb;
      repeat (BT) @(negedge clk);
    end
    rxd_b = stop;
    repeat (BT) @(negedge clk);
    rxd_b = 1'b1;
    repeat (BT) @(negedge clk);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin
    logic [7:0] v;
    int c0, t0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 txd idle", 8'(txd), 8'h01);
    chk("R1 irqs low", {6'd0, tx_irq, rx_irq}, 8'h00);
    bus_rd(2'd1, v); chk("R1 status", v, 8'h00);
    bus_rd(2'd0, v); chk("R1 control", v, 8'h00);

    // R2 8-bit, no parity, loopback
    loop_sel = 1'b1;
    bus_wr(2'd0, 8'h40);
    bus_rd(2'd0, v); chk("R13 control readback", v, 8'h40);
    send_tx(8'hA5, 1'b0, 1'b0, 10);
    send_tx(8'h00, 1'b0, 1'b0, 10);
    send_tx(8'hFF, 1'b0, 1'b0, 10);

    // R4 mode 01 is 8-bit, even parity then odd parity
    @(negedge clk); bus_wr(2'd0, 8'h4D);
    send_tx(8'h5A, 1'b0, 1'b0, 11);
    send_tx(8'h07, 1'b0, 1'b0, 11);
    @(negedge clk); bus_wr(2'd0, 8'h44);
    send_tx(8'h07, 1'b0, 1'b0, 11);

    // R10 a data write while busy is ignored
    @(negedge clk); bus_wr(2'd0, 8'h40);
    t0 = txi_cnt;
    @(negedge clk);
    bus_wr(2'd2, 8'hC3);
    bus_wr(2'd2, 8'h3C);
    push(8'hC3, 1'b0, 1'b0, 3'b000);
    wait (sb.size() == 0);
    repeat (3 * BT) @(negedge clk);
    chk("R10 single transmit", 8'(txi_cnt - t0), 8'h01);
    bus_rd(2'd1, v); chk("R10 status idle", v & 8'h7C, 8'h00);

    // R4 parity error, bench-driven line
    loop_sel = 1'b0;
    @(negedge clk); bus_wr(2'd0, 8'h4C);
    push(8'h07, 1'b0, 1'b0, 3'b010);
    ser_rx(8'h07, 1'b1, 1'b0, 1'b1);
    wait (sb.size() == 0);

    // R7 framing error, then R9 clear on read
    @(negedge clk); bus_wr(2'd0, 8'h40);
    push(8'h99, 1'b0, 1'b0, 3'b001);
    ser_rx(8'h99, 1'b0, 1'b0, 1'b0);
    wait (sb.size() == 0);
    @(negedge clk);
    bus_rd(2'd1, v); chk("R9 errors cleared", v & 8'h1C, 8'h00);

    // R8 overrun, R9 clear, R11 release
    mon_auto = 1'b0;
    ser_rx(8'h11, 1'b0, 1'b0, 1'b1);
    ser_rx(8'h22, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    bus_rd(2'd1, v); chk("R8 overrun flag", v & 8'h5C, 8'h50);
    bus_rd(2'd1, v); chk("R9 flag cleared by read", v & 8'h5C, 8'h40);
    bus_rd(2'd2, v); chk("R8 newest byte kept", v, 8'h22);
    bus_rd(2'd1, v); chk("R11 buffer released", v & 8'h5C, 8'h00);
    mon_auto = 1'b1;

    // R12 short glitch gives no frame
    c0 = rxi_cnt;
    @(negedge clk);
    rxd_b = 1'b0;
    repeat (2 * TK) @(negedge clk);
    rxd_b = 1'b1;
    repeat (2 * BT) @(negedge clk);
    chk("R12 glitch rejected", 8'(rxi_cnt - c0), 8'h00);
    bus_rd(2'd1, v); chk("R12 status untouched", v & 8'h5C, 8'h00);

    // R13 receiver disabled
    @(negedge clk); bus_wr(2'd0, 8'h00);
    c0 = rxi_cnt;
    ser_rx(8'h55, 1'b0, 1'b0, 1'b1);
    chk("R13 disabled receiver", 8'(rxi_cnt - c0), 8'h00);

    // R3 and R5: 9-bit mode with parity enable set, loopback
    loop_sel = 1'b1;
    @(negedge clk); bus_wr(2'd0, 8'h67);
    send_tx(8'h81, 1'b1, 1'b1, 11);
    @(negedge clk); bus_wr(2'd0, 8'h47);
    send_tx(8'h43, 1'b0, 1'b1, 11);

    // R6 wakeup: address frame accepted, data frame dropped
    loop_sel = 1'b0;
    @(negedge clk); bus_wr(2'd0, 8'h53);
    push(8'h11, 1'b1, 1'b1, 3'b000);
    ser_rx(8'h11, 1'b1, 1'b1, 1'b1);
    wait (sb.size() == 0);
    c0 = rxi_cnt;
    ser_rx(8'h22, 1'b1, 1'b0, 1'b1);
    chk("R6 no interrupt for data frame", 8'(rxi_cnt - c0), 8'h00);
    @(negedge clk);
    bus_rd(2'd1, v); chk("R6 status unchanged", v & 8'hDC, 8'h80);
    bus_rd(2'd2, v); chk("R6 buffer unchanged", v, 8'h11);

    repeat (10) @(negedge clk);
    report();
    $finish;
  end

endmodule